// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Per-Pin Interrupts

This block controls a bank of general-purpose pins from a simple 32-bit register bus with a write strobe and a read strobe. For every pin it stores an output value, an output-enable (direction) bit and two pull settings. The pull settings are only passed on to output ports for the pad ring. Software can overwrite the whole output word, or it can change single bits without a read-modify-write through a set port and a clear port. Pin inputs are synchronized before they are read back or used for interrupt detection.

Each pin has an interrupt detector. Three configuration words pick the trigger for each pin. One word selects level or edge. One word selects polarity, which means high or rising, or low or falling. One word asks for both edges. Detected events go into a pending word that software can read. Edge events stay latched until software acknowledges them by writing ones to the acknowledge port. A mask word decides which pending pins reach the single combined interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: After a synchronous reset, every stored register is zero, `pin_out`, `pin_oe`, the pull outputs and `irq` are 0, and the pending word reads 0.
- R2: A write to byte address 0x00 loads the output word, which drives `pin_out` from the next cycle. A write to 0x08 loads the direction word, which drives `pin_oe`, where 1 means output. Both read back at their addresses.
- R3: A write to 0x10 sets each output bit whose write bit is 1. A write to 0x14 clears each output bit whose write bit is 1. Bits written as 0 keep their value.
- R4: A read of 0x04 returns the pin levels after a two-flop synchronizer.
- R5: Words written to 0x18 (pull enable) and 0x1C (pull select) read back and drive `pull_en_o` and `pull_sel_o`.
- R6: When a pin's bit in the type word (0x34) is 1, its pending bit follows the active level while the pin is enabled (0x20). The active level is high when its polarity bit (0x3C) is 0 and low when it is 1. The bit is not latched.
- R7: When a pin's type bit is 0, a polarity bit of 0 latches a pending bit on a rising edge and a polarity bit of 1 latches it on a falling edge. The bit then stays set.
- R8: In edge mode, a pin whose both-edge bit (0x38) is 1 latches on rising and on falling edges, whatever its polarity bit says.
- R9: Writing 1s to 0x30 clears those pins' latched pending bits. Pending bits written as 0 are unaffected.
- R10: A pin whose enable bit is 0 raises no new pending bit.
- R11: `irq` is registered and equals the OR of (pending AND NOT mask) one cycle earlier. The mask word is at 0x2C, and a mask bit of 1 blocks that pin.
- R12: `rdata` is loaded on the edge where `rd_en` is sampled. Reads of the write-only addresses 0x10, 0x14, 0x30 and of unmapped addresses return 0. The pending word is at 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from pads |
| pin_out | output | 32 | Output values to pads |
| pin_oe | output | 32 | Output enables to pads |
| pull_en_o | output | 32 | Pull enable per pin |
| pull_sel_o | output | 32 | Pull select per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that at most one of the strobes acts on an address in any cycle, that reset is held for at least two clocks, and that `addr` and `wdata` are stable across the sampling edge. The stimulus drives every input on the falling edge, pulses one strobe at a time, and changes pin levels only when no write is in flight. It also waits several cycles after each pin change before reading, so the synchronizer latency never makes a result depend on timing.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // byte offsets, fixed because software decodes them
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SET    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEN    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PSEL   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_LVLSEL = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h3C;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] smp_now,
  output logic [WIDTH-1:0] smp_prev
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      smp_now  <= '0;
      smp_prev <= '0;
    end else begin
      meta_q   <= async_in;
      smp_now  <= meta_q;
      smp_prev <= smp_now;
    end
  end
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell (
  input  logic clk,
  input  logic rst,
  input  logic smp_now,
  input  logic smp_prev,
  input  logic lvl_mode,
  input  logic pol_low,
  input  logic both_edges,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  logic rise, fall, edge_hit, lvl_active;

  always_comb begin
    rise       = smp_now & ~smp_prev;
    fall       = ~smp_now & smp_prev;
    lvl_active = smp_now ^ pol_low;
    if (both_edges) edge_hit = rise | fall;
    else if (pol_low) edge_hit = fall;
    else edge_hit = rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (lvl_mode) begin
      pending <= enable & lvl_active;
    end else begin
      // a new event in the acknowledge cycle wins, so it is not lost
      pending <= (pending & ~ack) | (enable & edge_hit);
    end
  end
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pending,
  input  logic [NPINS-1:0] mask,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pending & ~mask);
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_en_o,
  output logic [NPINS-1:0]  pull_sel_o,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - NPINS;

  logic [NPINS-1:0] dout_r, dir_r, pen_r, psel_r;
  logic [NPINS-1:0] ien_r, mask_r, lvlsel_r, both_r, pol_r;
  logic [NPINS-1:0] smp_now, smp_prev, int_status, ack_vec;
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] rd_word;

  assign wbits   = wdata[NPINS-1:0];
  assign ack_vec = (wr_en && addr == OFS_ACK) ? wbits : '0;

  gpio_sync2 #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in),
    .smp_now(smp_now), .smp_prev(smp_prev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_r <= '0; dir_r <= '0; pen_r <= '0; psel_r <= '0;
      ien_r <= '0; mask_r <= '0; lvlsel_r <= '0; both_r <= '0; pol_r <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_DOUT:   dout_r   <= wbits;
        OFS_SET:    dout_r   <= dout_r | wbits;
        OFS_CLR:    dout_r   <= dout_r & ~wbits;
        OFS_DIR:    dir_r    <= wbits;
        OFS_PEN:    pen_r    <= wbits;
        OFS_PSEL:   psel_r   <= wbits;
        OFS_IEN:    ien_r    <= wbits;
        OFS_MASK:   mask_r   <= wbits;
        OFS_LVLSEL: lvlsel_r <= wbits;
        OFS_BOTH:   both_r   <= wbits;
        OFS_POL:    pol_r    <= wbits;
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_trig_cell u_cell (
      .clk(clk), .rst(rst),
      .smp_now(smp_now[p]), .smp_prev(smp_prev[p]),
      .lvl_mode(lvlsel_r[p]), .pol_low(pol_r[p]), .both_edges(both_r[p]),
      .enable(ien_r[p]), .ack(ack_vec[p]),
      .pending(int_status[p])
    );
  end

  gpio_irq_combine #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst(rst), .pending(int_status), .mask(mask_r), .irq(irq)
  );

  always_comb begin
    case (addr)
      OFS_DOUT:   rd_word = dout_r;
      OFS_DIN:    rd_word = smp_now;
      OFS_DIR:    rd_word = dir_r;
      OFS_PEN:    rd_word = pen_r;
      OFS_PSEL:   rd_word = psel_r;
      OFS_IEN:    rd_word = ien_r;
      OFS_PEND:   rd_word = int_status;
      OFS_MASK:   rd_word = mask_r;
      OFS_LVLSEL: rd_word = lvlsel_r;
      OFS_BOTH:   rd_word = both_r;
      OFS_POL:    rd_word = pol_r;
      default:    rd_word = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= {{PAD_W{1'b0}}, rd_word};
      end
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
      end
    end
  endgenerate

  assign pin_out    = dout_r;
  assign pin_oe     = dir_r;
  assign pull_en_o  = pen_r;
  assign pull_sel_o = psel_r;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  status,
  input logic [NPINS-1:0]  mask,
  input logic [NPINS-1:0]  enable,
  input logic              irq
);
  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status & ~mask)));

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SET) |=> pin_out == ($past(pin_out) | $past(wdata[NPINS-1:0])));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CLR) |=> pin_out == ($past(pin_out) & ~$past(wdata[NPINS-1:0])));

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DIR) |=> pin_oe == $past(wdata[NPINS-1:0]));

  assert_no_raise_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & ~$past(enable)) == '0);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .status(int_status), .mask(mask_r),
  .enable(ien_r), .irq(irq)
);

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe, pull_en_o, pull_sel_o;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [31:0] q_val[$];
  string       q_tag[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en_o(pull_en_o), .pull_sel_o(pull_sel_o), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    q_val.push_back(exp); q_tag.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: compare read data the cycle after the strobe was sampled
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (q_val.size() == 0) check("monitor: unexpected read", 32'h1, 32'h0);
      else check(q_tag.pop_front(), rdata, q_val.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pin_out", pin_out, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pull_en", pull_en_o, 0);
    check("R1 irq", {31'd0, irq}, 0);
    bus_rd(8'h24, 0, "R1 pending");
    bus_rd(8'h08, 0, "R1 direction");

    // R2 output and direction
    bus_wr(8'h00, 32'hA5A5_0F0F);
    check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    bus_wr(8'h08, 32'hFFFF_0000);
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    bus_rd(8'h00, 32'hA5A5_0F0F, "R2 dout readback");

    // R3 atomic set / clear
    bus_wr(8'h10, 32'h0000_00F0);
    check("R3 set", pin_out, 32'hA5A5_0FFF);
    bus_wr(8'h14, 32'h0500_0F00);
    check("R3 clear", pin_out, 32'hA0A5_00FF);
    bus_wr(8'h10, 32'h0);
    check("R3 zero set", pin_out, 32'hA0A5_00FF);

    // R12 write-only / unmapped reads
    bus_rd(8'h10, 0, "R12 set reads 0");
    bus_rd(8'h30, 0, "R12 ack reads 0");
    bus_rd(8'h28, 0, "R12 unmapped reads 0");

    // R4 synchronized input
    pin_in = 32'h1234_5678;
    settle();
    bus_rd(8'h04, 32'h1234_5678, "R4 data in");

    // R5 pulls
    bus_wr(8'h18, 32'hCAFE_0001);
    bus_wr(8'h1C, 32'h0000_FFFF);
    check("R5 pull_en", pull_en_o, 32'hCAFE_0001);
    check("R5 pull_sel", pull_sel_o, 32'h0000_FFFF);
    bus_rd(8'h1C, 32'h0000_FFFF, "R5 pull_sel readback");

    // R6 level mode: pin0 active high, pin1 active low
    pin_in = '0;
    settle();
    bus_wr(8'h34, 32'h3);
    bus_wr(8'h3C, 32'h2);
    bus_wr(8'h20, 32'h3);
    settle();
    bus_rd(8'h24, 32'h2, "R6 low-active pending");
    check("R11 irq on", {31'd0, irq}, 1);
    pin_in = 32'h3;
    settle();
    bus_rd(8'h24, 32'h1, "R6 high-active pending");
    pin_in = 32'h0;
    settle();
    bus_rd(8'h24, 32'h2, "R6 not latched");
    bus_wr(8'h20, 32'h0);
    settle();
    bus_rd(8'h24, 32'h0, "R10 level disabled");

    // R7/R8 edge mode: pin4 rising, pin5 falling, pin6 both (pol bit set)
    bus_wr(8'h34, 32'h0);
    bus_wr(8'h3C, 32'h60);
    bus_wr(8'h38, 32'h40);
    bus_wr(8'h30, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'h70);
    settle();
    bus_rd(8'h24, 32'h0, "R7 no edge yet");
    pin_in = 32'h70;
    settle();
    bus_rd(8'h24, 32'h50, "R7 R8 rising");
    pin_in = 32'h0;
    settle();
    bus_rd(8'h24, 32'h70, "R7 R8 falling latched");
    bus_rd(8'h38, 32'h40, "R8 both readback");

    // R9 acknowledge
    bus_wr(8'h30, 32'h10);
    bus_rd(8'h24, 32'h60, "R9 partial ack");
    bus_wr(8'h30, 32'hFFFF_FFFF);
    bus_rd(8'h24, 32'h0, "R9 full ack");
    settle();
    check("R11 irq off", {31'd0, irq}, 0);

    // R11 mask
    pin_in = 32'h40;
    settle();
    check("R11 irq unmasked", {31'd0, irq}, 1);
    bus_wr(8'h2C, 32'h40);
    @(negedge clk);
    check("R11 irq masked", {31'd0, irq}, 0);
    bus_wr(8'h2C, 32'h0);
    @(negedge clk);
    check("R11 irq unmasked again", {31'd0, irq}, 1);
    bus_wr(8'h30, 32'hFFFF_FFFF);

    // R10 disabled edge
    bus_wr(8'h20, 32'h0);
    pin_in = 32'h10;
    settle();
    pin_in = 32'h0;
    settle();
    bus_rd(8'h24, 32'h0, "R10 edge disabled");
    check("R10 irq", {31'd0, irq}, 0);

    repeat (3) @(negedge clk);
    if (q_val.size() != 0) check("monitor: reads pending", q_val.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule